// File: doc/BRIEF.md
# Serial Control Register Bank with Bus Slave

This block is a 7-bit-address I2C slave. It holds a short bank of write-only control bytes and one read-only identity byte. SCL and SDA are oversampled with the system clock. The block finds START and STOP conditions, matches its own address and acknowledges it. It then loads incoming bytes into the bank, or sends the identity byte back to the master. The SDA pin is open-drain, so the block only ever pulls it low through an output enable.

A write carries no register pointer. The first data byte after the address always lands in register 0, and each later byte goes to the next register. To change register N, a master therefore sends registers 0 through N in one transfer. A write to the general-call address 0x00 whose first data byte is 0x06 puts every register back to its power-up value.

The bank contents are exported as one flat vector, together with decoded controls: an audio mute, a 3-bit input select, left and right source selectors, and two general-purpose output levels. None of these outputs is a stream, so every pin is a plain level with no handshake.

Top module: `i2c_ctrl_bank`

## Requirements
- R1: After reset, register 0 holds 8'h80 (muted), registers 1 to 4 hold 8'h00, and SDA is released (`sda_oe` = 0).
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. An address byte whose upper seven bits are 7'b1001000 is acknowledged: SDA is pulled low from the falling SCL edge after the eighth bit until the falling edge that ends the ninth clock. Any other address, except the general-call byte 8'h00, gets no acknowledge, and the slave stays silent until the next START.
- R3: In a write (eighth address bit 0), data bytes are sampled MSB first on rising SCL. They load register 0, then 1, and so on, and each byte is acknowledged. Every START, repeated starts included, points the next write back at register 0.
- R4: Data bytes after the fifth (register 4) are still acknowledged, but they change no register.
- R5: In a read (eighth address bit 1), the slave sends the identity byte {4'b0001, ID_LO}, MSB first, on the next eight SCL clocks. With the default ID_LO = 4'h0 this byte is 8'h10. SDA is released for the master's acknowledge bit and stays released afterwards.
- R6: Address byte 8'h00 followed by data byte 8'h06 restores every register to its R1 value. Any other first data byte after 8'h00 changes nothing.
- R7: `aux_mute` equals register 0 bit 7, and `in_sel` equals register 1 bits 5:3.
- R8: Register 3 bits 7:6 choose the sources. The selector codes are 0 = left input, 1 = right input and 2 = left-plus-right sum. The field values map as follows:
  - 00: left output = 0, right output = 1.
  - 01: both outputs = 2.
  - 10: both outputs = 0.
  - 11: both outputs = 1.
- R9: `gpo[1:0]` equals register 3 bits 1:0. A 0 bit gives a low output and a 1 bit gives a high output.
- R10: SDA is only ever pulled low, never driven high, and it is released whenever a START or a STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_flat | output | NUM_REGS*8 | Register contents, register i in bits [i*8+7:i*8] |
| aux_mute | output | 1 | Mute control for the auxiliary outputs |
| in_sel | output | 3 | Input select field |
| lsrc_sel | output | 2 | Left output source code |
| rsrc_sel | output | 2 | Right output source code |
| gpo | output | 2 | General-purpose output levels |

## Verification
The states that are hardest to reach are the ones that appear only deep inside a transfer. One is a general-call transfer with exactly 0x06 as its first data byte. Another is a repeated START arriving after the write pointer has already advanced. A third is the sixth and seventh data bytes, which are sent past the end of the bank. The bench drives real bus waveforms as an open-drain master and builds all three situations as full transactions. A behavioural model follows each committed byte, and every register and decoded output is compared against it on each clock. The acknowledge and read-data bits are sampled on the wired-AND SDA line while SCL is high.

// File: rtl/i2c_bank_pkg.sv
package i2c_bank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    SRC_LEFT  = 2'd0,
    SRC_RIGHT = 2'd1,
    SRC_SUM   = 2'd2
  } src_e;

  localparam logic [3:0] FAMILY_ID = 4'b0001;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;

  localparam int MUTE_REG  = 0;
  localparam int MUTE_BIT  = 7;
  localparam int INSEL_REG = 1;
  localparam int INSEL_LSB = 3;
  localparam int SRC_REG   = 3;
  localparam int SRC_LSB   = 6;
  localparam int GPO_REG   = 3;
  localparam int GPO_LSB   = 0;

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == MUTE_REG) ? 8'h80 : 8'h00;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         NUM_REGS = 5,
  parameter logic [7:0] ID_BYTE  = 8'h10,
  parameter int         IDXW     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            bank_clr
);

  bus_st_e       st;
  logic [3:0]    cnt;
  logic [7:0]    shreg;
  logic [7:0]    nxt;
  logic [IDXW:0] ptr;
  logic          is_rd, is_gc, hit, first;

  assign nxt = {shreg[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      ptr      <= '0;
      is_rd    <= 1'b0;
      is_gc    <= 1'b0;
      hit      <= 1'b0;
      first    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      bank_clr <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      bank_clr <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        ptr    <= '0;
        is_gc  <= 1'b0;
        first  <= 1'b1;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= nxt;
              cnt   <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                is_rd <= sda_s;
                is_gc <= (nxt == 8'h00);
                hit   <= (nxt[7:1] == DEV_ADDR) || (nxt == 8'h00);
              end
            end else if (scl_fall && cnt == 4'd8) begin
              if (hit) begin
                st     <= ST_AACK;
                sda_oe <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_rd) begin
                st     <= ST_RD;
                sda_oe <= ~ID_BYTE[7];
              end else begin
                st     <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg <= nxt;
              cnt   <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                first <= 1'b0;
                if (is_gc) begin
                  if (first && nxt == GC_RESET_CMD) bank_clr <= 1'b1;
                end else if (int'(ptr) < NUM_REGS) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr[IDXW-1:0];
                  wr_data <= nxt;
                  ptr     <= ptr + 1'b1;
                end
              end
            end else if (scl_fall && cnt == 4'd8) begin
              st     <= ST_WACK;
              sda_oe <= 1'b1;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              st     <= ST_WR;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                st     <= ST_SKIP;
                sda_oe <= 1'b0;
              end else begin
                sda_oe <= ~ID_BYTE[3'd7 - cnt[2:0]];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_bank_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int IDXW     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  bank_clr,
  output logic [NUM_REGS*8-1:0] reg_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DFLT = reg_default(g);
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                r <= DFLT;
      else if (bank_clr)                         r <= DFLT;
      else if (wr_en && wr_idx == IDXW'(g))      r <= wr_data;
    end
    assign reg_flat[g*8 +: 8] = r;
  end

endmodule

// File: rtl/i2c_ctrl_decode.sv
module i2c_ctrl_decode
  import i2c_bank_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input  logic [NUM_REGS*8-1:0] reg_flat,
  output logic                  aux_mute,
  output logic [2:0]            in_sel,
  output logic [1:0]            lsrc_sel,
  output logic [1:0]            rsrc_sel,
  output logic [1:0]            gpo
);

  logic [7:0] r_mute, r_in, r_src, r_gpo;
  src_e l_src, r_src_e;

  assign r_mute = reg_flat[MUTE_REG*8 +: 8];
  assign r_in   = reg_flat[INSEL_REG*8 +: 8];
  assign r_src  = reg_flat[SRC_REG*8 +: 8];
  assign r_gpo  = reg_flat[GPO_REG*8 +: 8];

  assign aux_mute = r_mute[MUTE_BIT];
  assign in_sel   = r_in[INSEL_LSB +: 3];
  assign gpo      = r_gpo[GPO_LSB +: 2];

  always_comb begin
    unique case (r_src[SRC_LSB +: 2])
      2'b00:   begin l_src = SRC_LEFT;  r_src_e = SRC_RIGHT; end
      2'b01:   begin l_src = SRC_SUM;   r_src_e = SRC_SUM;   end
      2'b10:   begin l_src = SRC_LEFT;  r_src_e = SRC_LEFT;  end
      default: begin l_src = SRC_RIGHT; r_src_e = SRC_RIGHT; end
    endcase
  end

  assign lsrc_sel = l_src;
  assign rsrc_sel = r_src_e;

endmodule

// File: rtl/i2c_ctrl_bank.sv
module i2c_ctrl_bank
  import i2c_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         NUM_REGS    = 5,
  parameter logic [3:0] ID_LO       = 4'h0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_flat,
  output logic                  aux_mute,
  output logic [2:0]            in_sel,
  output logic [1:0]            lsrc_sel,
  output logic [1:0]            rsrc_sel,
  output logic [1:0]            gpo
);

  localparam int         IDXW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] ID_BYTE = {FAMILY_ID, ID_LO};

  logic            sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic            wr_en, bank_clr;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_slave_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .ID_BYTE  (ID_BYTE),
    .IDXW     (IDXW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .bank_clr  (bank_clr)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .bank_clr (bank_clr),
    .reg_flat (reg_flat)
  );

  i2c_ctrl_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .reg_flat (reg_flat),
    .aux_mute (aux_mute),
    .in_sel   (in_sel),
    .lsrc_sel (lsrc_sel),
    .rsrc_sel (rsrc_sel),
    .gpo      (gpo)
  );

endmodule

// File: rtl/i2c_ctrl_bank_chk.sv
module i2c_ctrl_bank_chk
  import i2c_bank_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int IDXW     = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic                  wr_en,
  input logic [IDXW-1:0]       wr_idx,
  input logic                  bank_clr,
  input logic [NUM_REGS*8-1:0] reg_flat,
  input logic [1:0]            lsrc_sel,
  input logic [1:0]            rsrc_sel
);

  logic [NUM_REGS*8-1:0] dflt;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) dflt[i*8 +: 8] = reg_default(i);
  end

  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> reg_flat == dflt); // R1
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R2
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bank_clr) |=> $stable(reg_flat)); // R3
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_idx) < NUM_REGS); // R4
  AST_CLEAR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    bank_clr |=> reg_flat == dflt); // R6
  AST_SRC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    lsrc_sel != 2'd3 && rsrc_sel != 2'd3); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R10

endmodule

bind i2c_ctrl_bank i2c_ctrl_bank_chk #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .bank_clr  (bank_clr),
  .reg_flat  (reg_flat),
  .lsrc_sel  (lsrc_sel),
  .rsrc_sel  (rsrc_sel)
);

// File: tb/test_i2c_ctrl_bank.sv
module test_i2c_ctrl_bank;

  localparam int NR   = 5;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] reg_flat;
  logic aux_mute;
  logic [2:0] in_sel;
  logic [1:0] lsrc_sel, rsrc_sel, gpo;
  logic sda_line;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_reg[NR];
  int  m_ptr;
  bit  m_gc, m_first;
  logic [7:0] txq[$];

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_ctrl_bank i_i2c_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_flat(reg_flat), .aux_mute(aux_mute),
    .in_sel(in_sel), .lsrc_sel(lsrc_sel), .rsrc_sel(rsrc_sel), .gpo(gpo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] exp_flat();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = exp_reg[i];
    return v;
  endfunction

  function automatic logic [3:0] exp_src(input logic [1:0] mode);
    case (mode)
      2'b00:   return {2'd0, 2'd1};
      2'b01:   return {2'd2, 2'd2};
      2'b10:   return {2'd0, 2'd0};
      default: return {2'd1, 2'd1};
    endcase
  endfunction

  task automatic model_reset();
    exp_reg[0] = 8'h80;
    for (int i = 1; i < NR; i++) exp_reg[i] = 8'h00;
  endtask

  task automatic model_start(input logic [7:0] abyte);
    m_ptr = 0;
    m_gc = (abyte == 8'h00);
    m_first = 1'b1;
  endtask

  task automatic model_data(input logic [7:0] b);
    if (m_gc) begin
      if (m_first && b == 8'h06) model_reset();
    end else if (m_ptr < NR) begin
      exp_reg[m_ptr] = b;
      m_ptr++;
    end
    m_first = 1'b0;
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [3:0] s;
      s = exp_src(exp_reg[3][7:6]);
      chk(reg_flat == exp_flat(), "R3", "per-clock bank", reg_flat, exp_flat());
      chk(aux_mute == exp_reg[0][7] && in_sel == exp_reg[1][5:3], "R7",
          "per-clock mute/in_sel", {aux_mute, in_sel}, {exp_reg[0][7], exp_reg[1][5:3]});
      chk({lsrc_sel, rsrc_sel} == s, "R8", "per-clock sources", {lsrc_sel, rsrc_sel}, s);
      chk(gpo == exp_reg[3][1:0], "R9", "per-clock gpo", gpo, exp_reg[3][1:0]);
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; clks(HALF);
    scl_m = 1'b1; clks(HALF);
    sda_m = 1'b0; clks(HALF);
    scl_m = 1'b0; clks(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; clks(HALF);
    scl_m = 1'b1; clks(HALF);
    sda_m = 1'b1; clks(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit is_data, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; clks(HALF);
      scl_m = 1'b1;
      if (i == 0 && is_data) begin
        repeat (4) @(posedge clk);
        #1 model_data(b);
        clks(HALF - 4);
      end else begin
        clks(HALF);
      end
      scl_m = 1'b0;
    end
    sda_m = 1'b1; clks(HALF);
    scl_m = 1'b1; clks(HALF / 2);
    acked = (sda_line == 1'b0);
    clks(HALF / 2);
    scl_m = 1'b0; clks(2);
  endtask

  task automatic write_txn(input logic [7:0] abyte, input bit exp_ack,
                           input string req, input bit with_stop);
    bit ack;
    bus_start();
    model_start(abyte);
    send_byte(abyte, 1'b0, ack);
    chk(ack == exp_ack, req, "address acknowledge", ack, exp_ack);
    foreach (txq[k]) begin
      send_byte(txq[k], exp_ack, ack);
      chk(ack == exp_ack, req, $sformatf("data byte %0d acknowledge", k), ack, exp_ack);
    end
    if (with_stop) begin
      bus_stop();
      clks(4);
      chk(sda_oe == 1'b0, "R10", "released after STOP", sda_oe, 0);
    end
  endtask

  task automatic read_txn(output logic [7:0] got);
    bit ack;
    bus_start();
    model_start(8'h91);
    send_byte(8'h91, 1'b0, ack);
    chk(ack == 1'b1, "R5", "read address acknowledge", ack, 1);
    for (int i = 7; i >= 0; i--) begin
      clks(HALF);
      scl_m = 1'b1; clks(HALF / 2);
      got[i] = sda_line;
      clks(HALF / 2);
      scl_m = 1'b0;
    end
    clks(HALF);
    scl_m = 1'b1; clks(HALF / 2);
    chk(sda_oe == 1'b0, "R5", "released during master acknowledge", sda_oe, 0);
    clks(HALF / 2);
    scl_m = 1'b0; clks(HALF);
    chk(sda_oe == 1'b0, "R5", "released after read byte", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [NR*8-1:0] snap;
    model_reset();
    clks(5);
    rst_n = 1'b1;
    clks(2);
    // R1 reset state
    chk(reg_flat == exp_flat(), "R1", "reset bank", reg_flat, exp_flat());
    chk(sda_oe == 1'b0, "R1", "reset sda released", sda_oe, 0);
    chk(aux_mute == 1'b1, "R7", "reset muted", aux_mute, 1);
    chk({lsrc_sel, rsrc_sel} == 4'b0001, "R8", "reset stereo", {lsrc_sel, rsrc_sel}, 1);
    cmp_on = 1'b1;

    // R3 fill all five registers
    txq.delete();
    txq.push_back(8'h11); txq.push_back(8'h28); txq.push_back(8'h33);
    txq.push_back(8'h42); txq.push_back(8'h5A);
    write_txn(8'h90, 1'b1, "R3", 1'b1);
    chk(reg_flat == 40'h5A42332811, "R3", "five-byte write", reg_flat, 40'h5A42332811);
    chk(aux_mute == 1'b0 && in_sel == 3'd5, "R7", "unmuted, in_sel", {aux_mute, in_sel}, 4'h5);

    // R3 short write touches only registers 0 and 1
    txq.delete();
    txq.push_back(8'h80); txq.push_back(8'h10);
    write_txn(8'h90, 1'b1, "R3", 1'b1);
    chk(reg_flat == 40'h5A42331080, "R3", "two-byte write", reg_flat, 40'h5A42331080);
    chk(in_sel == 3'd2 && aux_mute == 1'b1, "R7", "muted, in_sel", {aux_mute, in_sel}, 4'hA);

    // R4 bytes past the bank
    txq.delete();
    for (int i = 0; i < 7; i++) txq.push_back(8'(8'hA0 + i));
    write_txn(8'h90, 1'b1, "R4", 1'b1);
    chk(reg_flat == 40'hA4A3A2A1A0, "R4", "overflow bytes discarded", reg_flat, 40'hA4A3A2A1A0);

    // R8 and R9: every source mode with the output levels
    for (int m = 0; m < 4; m++) begin
      logic [7:0] r3;
      r3 = {m[1:0], 4'b0000, m[0], ~m[0]};
      txq.delete();
      txq.push_back(8'h00); txq.push_back(8'h00); txq.push_back(8'h00); txq.push_back(r3);
      write_txn(8'h90, 1'b1, "R8", 1'b1);
      chk({lsrc_sel, rsrc_sel} == exp_src(m[1:0]), "R8", $sformatf("mode %0d", m),
          {lsrc_sel, rsrc_sel}, exp_src(m[1:0]));
      chk(gpo == r3[1:0], "R9", $sformatf("gpo mode %0d", m), gpo, r3[1:0]);
    end

    // R2 non-matching address: no acknowledge, nothing changes
    snap = reg_flat;
    txq.delete();
    txq.push_back(8'hFF); txq.push_back(8'h77);
    write_txn(8'h92, 1'b0, "R2", 1'b1);
    chk(reg_flat == snap, "R2", "foreign address ignored", reg_flat, snap);

    // R3 repeated START restarts at register 0
    txq.delete();
    txq.push_back(8'hAA); txq.push_back(8'hBB);
    write_txn(8'h90, 1'b1, "R3", 1'b0);
    txq.delete();
    txq.push_back(8'h55);
    write_txn(8'h90, 1'b1, "R3", 1'b1);
    chk(reg_flat[15:0] == 16'hBB55, "R3", "repeated start pointer", reg_flat[15:0], 16'hBB55);

    // R5 read of the identity byte
    read_txn(rd);
    chk(rd == 8'h10, "R5", "identity byte", rd, 8'h10);

    // R6 general call with other data: no effect
    snap = reg_flat;
    txq.delete();
    txq.push_back(8'h05); txq.push_back(8'h06);
    write_txn(8'h00, 1'b1, "R6", 1'b1);
    chk(reg_flat == snap, "R6", "general call non-reset data", reg_flat, snap);

    // R6 general-call reset
    txq.delete();
    txq.push_back(8'h06);
    write_txn(8'h00, 1'b1, "R6", 1'b1);
    chk(reg_flat == 40'h0000000080, "R6", "general call reset", reg_flat, 40'h80);
    chk(aux_mute == 1'b1 && gpo == 2'b00, "R6", "defaults decoded", {aux_mute, gpo}, 4);

    clks(20);
    done = 1'b1;
    cmp_on = 1'b0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule